// File: doc/BRIEF.md
# Circular Floating-Point Register Stack

This block holds eight 80-bit extended-precision values arranged as a circular stack. A 3-bit top pointer selects the current stack top, and every operand is named by its distance from that pointer: ST(i) is physical entry (top + i) mod 8. Each entry carries a 2-bit tag. Tag value 2'b00 marks an entry as valid and 2'b11 marks it as empty. The tags let the block detect a push onto a live entry (overflow) and any access to a dead entry (underflow).

An instruction sequencer presents one operation per cycle on `op_vld`/`op_code`, with `op_idx` naming ST(i). The block does no arithmetic. `rd_a` always shows ST(0). `rd_b` shows ST(1) during a stack-arithmetic operation and ST(op_idx) otherwise. An external unit combines these two and returns the result combinationally on `res_data` in the same cycle. The block then writes the result back and pops the stack. `top_o` is meant to be packed into bits 13:11 of a status word.

Opcode values are PUSH = 0, POP = 1, READ = 2, ARITH = 3 and REGPOP = 4. Values 5 to 7 are reserved.

Top module: `fpstk_regfile`

## Requirements
- R1: After reset, `top_o` is 0, every tag in `tag_o` is 2'b11, and `ovf_o` and `unf_o` are 0. Entry k's tag sits at `tag_o[2k+1:2k]`.
- R2: PUSH (code 0) into an empty slot decrements `top_o` modulo 8, so 0 wraps to 7. It writes `push_data` into the new top and sets that entry's tag to 2'b00. The value then appears on `rd_a`.
- R3: PUSH when the slot at (top − 1) mod 8 is valid raises `ovf_o` for one cycle, in the cycle after the operation. Pointer, tags and contents stay unchanged, and `unf_o` stays low.
- R4: POP (code 1) on a valid ST(0) sets that entry's tag to 2'b11 and increments `top_o` modulo 8, so 7 wraps to 0. Before the edge, `rd_a` presents the popped value.
- R5: While any operation is presented, `rd_a` equals entry `top_o` and `rd_b` equals entry (top + op_idx) mod 8. The exception is ARITH, covered in R6. READ (code 2) changes no state.
- R6: During ARITH (code 3), `rd_b` shows ST(1). If ST(0) and ST(1) are both valid, `res_data` is written to ST(1), the old ST(0) is tagged empty and `top_o` increments. The result is therefore the new ST(0).
- R7: REGPOP (code 4) with ST(0) and ST(op_idx) both valid writes `res_data` into ST(op_idx) and then pops once. When op_idx is 0, the written entry is the one released.
- R8: POP with an empty ST(0), READ of an empty ST(op_idx), ARITH with ST(0) or ST(1) empty, or REGPOP with ST(0) or ST(op_idx) empty raises `unf_o` for one cycle, in the cycle after the operation. No pointer, tag or data changes.
- R9: Reserved codes 5 to 7, and any cycle with `op_vld` low, change no state and raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_vld | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation code (see R2 to R9) |
| op_idx | input | 3 | Relative operand index i of ST(i) |
| push_data | input | 80 | Value written by PUSH |
| res_data | input | 80 | Combinational result from the external arithmetic unit |
| rd_a | output | 80 | Contents of ST(0) |
| rd_b | output | 80 | Contents of ST(1) during ARITH, else ST(op_idx) |
| top_o | output | 3 | Top-of-stack pointer |
| tag_o | output | 16 | Packed per-entry tags, 2'b00 valid, 2'b11 empty |
| ovf_o | output | 1 | Stack overflow pulse |
| unf_o | output | 1 | Stack underflow pulse |

## Verification
The assertions assume that `op_code`, `op_idx` and both data inputs are stable around the clock edge while `op_vld` is high. They also assume that `res_data` is a valid value for any cycle in which ARITH or REGPOP is accepted. The bench drives every input on the falling edge and holds it through the next rising edge, then idles `op_vld`. The random phase draws reserved codes as well as legal ones, so the no-effect rule is exercised under the same input discipline. Pushes are weighted above pops so that the stack reaches both full and empty and hits the overflow and underflow cases repeatedly.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  typedef logic [1:0] tag_t;
  localparam tag_t TAG_VALID = 2'b00;
  localparam tag_t TAG_EMPTY = 2'b11;

  typedef enum logic [2:0] {
    OP_PUSH   = 3'd0,
    OP_POP    = 3'd1,
    OP_READ   = 3'd2,
    OP_ARITH  = 3'd3,
    OP_REGPOP = 3'd4,
    OP_RSV5   = 3'd5,
    OP_RSV6   = 3'd6,
    OP_RSV7   = 3'd7
  } op_e;
endpackage

// File: rtl/fpstk_ptr.sv
module fpstk_ptr #(
  parameter int unsigned PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_i,
  input  logic             inc_i,
  output logic [PTR_W-1:0] top_o
);
  logic [PTR_W-1:0] top_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     top_q <= '0;
    else if (dec_i) top_q <= top_q - 1'b1;
    else if (inc_i) top_q <= top_q + 1'b1;
  end

  assign top_o = top_q;

  // R2/R4: a cycle never both pushes and pops the pointer
  p_one_move_r4: assert property (@(posedge clk) disable iff (!rst_n) !(dec_i && inc_i));
endmodule

// File: rtl/fpstk_tags.sv
module fpstk_tags
  import fpstk_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_i,
  input  logic [IDX_W-1:0]   set_idx_i,
  input  logic               clr_i,
  input  logic [IDX_W-1:0]   clr_idx_i,
  output logic [2*DEPTH-1:0] tags_o
);
  genvar k;
  generate
    for (k = 0; k < DEPTH; k++) begin : g_tag
      tag_t tag_q;
      always_ff @(posedge clk) begin
        if (!rst_n) tag_q <= TAG_EMPTY;
        else if (clr_i && clr_idx_i == IDX_W'(k)) tag_q <= TAG_EMPTY;
        else if (set_i && set_idx_i == IDX_W'(k)) tag_q <= TAG_VALID;
      end
      assign tags_o[2*k +: 2] = tag_q;
    end
  endgenerate

  // R4: set comes only from a push and clear only from a pop, never both
  p_tag_one_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n) !(set_i && clr_i));
endmodule

// File: rtl/fpstk_regs.sv
module fpstk_regs #(
  parameter int unsigned FP_W  = 80,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [FP_W-1:0]  wdata_i,
  input  logic [IDX_W-1:0] ridx_a_i,
  input  logic [IDX_W-1:0] ridx_b_i,
  output logic [FP_W-1:0]  rdata_a_o,
  output logic [FP_W-1:0]  rdata_b_o
);
  logic [FP_W-1:0] mem [DEPTH];

  genvar k;
  generate
    for (k = 0; k < DEPTH; k++) begin : g_ent
      always_ff @(posedge clk) begin
        if (we_i && widx_i == IDX_W'(k)) mem[k] <= wdata_i;
      end
    end
  endgenerate

  assign rdata_a_o = mem[ridx_a_i];
  assign rdata_b_o = mem[ridx_b_i];
endmodule

// File: rtl/fpstk_regfile.sv
module fpstk_regfile
  import fpstk_pkg::*;
#(
  parameter int unsigned FP_W  = 80,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_vld,
  input  logic [2:0]         op_code,
  input  logic [PTR_W-1:0]   op_idx,
  input  logic [FP_W-1:0]    push_data,
  input  logic [FP_W-1:0]    res_data,
  output logic [FP_W-1:0]    rd_a,
  output logic [FP_W-1:0]    rd_b,
  output logic [PTR_W-1:0]   top_o,
  output logic [2*DEPTH-1:0] tag_o,
  output logic               ovf_o,
  output logic               unf_o
);
  typedef logic [PTR_W-1:0] ptr_t;

  function automatic ptr_t rel_slot(input ptr_t top, input ptr_t rel);
    return ptr_t'(top + rel);
  endfunction

  function automatic logic slot_empty(input logic [2*DEPTH-1:0] tags, input ptr_t s);
    return tags[2*s +: 2] == TAG_EMPTY;
  endfunction

  op_e  op;
  ptr_t st1_slot, sti_slot, push_slot, rb_slot, widx;
  logic e0, e1, ei, ep;
  logic is_push, is_pop, is_read, is_arith, is_regpop;
  logic ovf_ev, unf_ev, push_ev, pop_ev, wr_ev;
  logic [FP_W-1:0] wdata;

  assign op        = op_e'(op_code);
  assign is_push   = op_vld && op == OP_PUSH;
  assign is_pop    = op_vld && op == OP_POP;
  assign is_read   = op_vld && op == OP_READ;
  assign is_arith  = op_vld && op == OP_ARITH;
  assign is_regpop = op_vld && op == OP_REGPOP;

  assign st1_slot  = rel_slot(top_o, ptr_t'(1));
  assign sti_slot  = rel_slot(top_o, op_idx);
  assign push_slot = ptr_t'(top_o - 1'b1);
  assign rb_slot   = is_arith ? st1_slot : sti_slot;

  assign e0 = slot_empty(tag_o, top_o);
  assign e1 = slot_empty(tag_o, st1_slot);
  assign ei = slot_empty(tag_o, sti_slot);
  assign ep = slot_empty(tag_o, push_slot);

  // named internal events
  assign ovf_ev  = is_push && !ep;
  assign unf_ev  = (is_pop && e0) || (is_read && ei) ||
                   (is_arith && (e0 || e1)) || (is_regpop && (e0 || ei));
  assign push_ev = is_push && !ovf_ev;
  assign pop_ev  = (is_pop || is_arith || is_regpop) && !unf_ev;
  assign wr_ev   = push_ev || ((is_arith || is_regpop) && !unf_ev);
  assign widx    = is_push ? push_slot : (is_arith ? st1_slot : sti_slot);
  assign wdata   = is_push ? push_data : res_data;

  fpstk_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .dec_i(push_ev), .inc_i(pop_ev), .top_o(top_o)
  );

  fpstk_tags #(.DEPTH(DEPTH)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .set_i(push_ev), .set_idx_i(push_slot),
    .clr_i(pop_ev), .clr_idx_i(top_o),
    .tags_o(tag_o)
  );

  fpstk_regs #(.FP_W(FP_W), .DEPTH(DEPTH)) u_regs (
    .clk(clk), .we_i(wr_ev), .widx_i(widx), .wdata_i(wdata),
    .ridx_a_i(top_o), .ridx_b_i(rb_slot),
    .rdata_a_o(rd_a), .rdata_b_o(rd_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      ovf_o <= ovf_ev;
      unf_o <= unf_ev;
    end
  end

  // R2: an accepted push moves the pointer down by one and validates the new top
  p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |=> top_o == ptr_t'($past(top_o) - 1'b1) && tag_o[2*top_o +: 2] == TAG_VALID);
  // R3: a refused push flags overflow and freezes pointer and tags
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> ovf_o && !unf_o && $stable(top_o) && $stable(tag_o));
  // R4: an accepted pop moves the pointer up and empties the released entry
  p_pop_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ev |=> top_o == ptr_t'($past(top_o) + 1'b1) &&
               tag_o[2*$past(top_o) +: 2] == TAG_EMPTY);
  // R5: a read leaves the state alone
  p_read_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_read |=> $stable(top_o) && $stable(tag_o));
  // R8: underflow flags and freezes the state
  p_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unf_ev |=> unf_o && $stable(top_o) && $stable(tag_o));
  // R9: no operation, no change
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_vld |=> $stable(top_o) && $stable(tag_o) && !ovf_o && !unf_o);
endmodule

// File: tb/tb_fpstk_regfile.sv
module tb_fpstk_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_vld;
  logic [2:0]  op_code;
  logic [2:0]  op_idx;
  logic [79:0] push_data;
  logic [79:0] res_data;
  logic [79:0] rd_a, rd_b;
  logic [2:0]  top_o;
  logic [15:0] tag_o;
  logic        ovf_o, unf_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [79:0] m_reg [8];
  logic [1:0]  m_tag [8];
  logic [2:0]  m_top;

  always #5 clk = ~clk;

  fpstk_regfile dut (
    .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_code(op_code), .op_idx(op_idx),
    .push_data(push_data), .res_data(res_data), .rd_a(rd_a), .rd_b(rd_b),
    .top_o(top_o), .tag_o(tag_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic chk(input string rq, input string what, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic chk_state(input string rq);
    chk(rq, "top", 80'(top_o), 80'(m_top));
    for (int k = 0; k < 8; k++) chk(rq, $sformatf("tag%0d", k), 80'(tag_o[2*k +: 2]), 80'(m_tag[k]));
    if (m_tag[m_top] == 2'b00) chk(rq, "rd_a after", rd_a, m_reg[m_top]);
  endtask

  function automatic logic [79:0] mkval(input int s);
    return {16'(s * 7 + 3), 32'(s * 32'h9E3779B9), 32'(~s)};
  endfunction

  task automatic run_op(input logic [2:0] code, input logic [2:0] idx,
                        input logic [79:0] pd, input logic [79:0] rs);
    string rq;
    logic [2:0] t1, ti, pt, rb;
    logic eo, eu;
    @(negedge clk);
    op_vld = 1'b1; op_code = code; op_idx = idx; push_data = pd; res_data = rs;
    #1;
    t1 = m_top + 3'd1;
    ti = m_top + idx;
    pt = m_top - 3'd1;
    rb = (code == 3'd3) ? t1 : ti;
    if (m_tag[m_top] == 2'b00) chk("R5", "rd_a", rd_a, m_reg[m_top]);
    if (m_tag[rb] == 2'b00) chk(code == 3'd3 ? "R6" : "R5", "rd_b", rd_b, m_reg[rb]);
    eo = 1'b0; eu = 1'b0;
    case (code)
      3'd0: begin
        if (m_tag[pt] == 2'b00) begin eo = 1'b1; rq = "R3"; end
        else begin m_top = pt; m_reg[pt] = pd; m_tag[pt] = 2'b00; rq = "R2"; end
      end
      3'd1: begin
        if (m_tag[m_top] == 2'b11) begin eu = 1'b1; rq = "R8"; end
        else begin m_tag[m_top] = 2'b11; m_top = t1; rq = "R4"; end
      end
      3'd2: begin
        eu = (m_tag[ti] == 2'b11);
        rq = eu ? "R8" : "R5";
      end
      3'd3: begin
        if (m_tag[m_top] == 2'b11 || m_tag[t1] == 2'b11) begin eu = 1'b1; rq = "R8"; end
        else begin m_reg[t1] = rs; m_tag[m_top] = 2'b11; m_top = t1; rq = "R6"; end
      end
      3'd4: begin
        if (m_tag[m_top] == 2'b11 || m_tag[ti] == 2'b11) begin eu = 1'b1; rq = "R8"; end
        else begin m_reg[ti] = rs; m_tag[m_top] = 2'b11; m_top = t1; rq = "R7"; end
      end
      default: rq = "R9";
    endcase
    @(posedge clk); #1;
    chk(rq, "ovf", 80'(ovf_o), 80'(eo));
    chk(rq, "unf", 80'(unf_o), 80'(eu));
    chk_state(rq);
    op_vld = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    rst_n = 1'b0; op_vld = 1'b0; op_code = '0; op_idx = '0; push_data = '0; res_data = '0;
    m_top = '0;
    for (int k = 0; k < 8; k++) begin m_tag[k] = 2'b11; m_reg[k] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "ovf", 80'(ovf_o), 80'(0));
    chk("R1", "unf", 80'(unf_o), 80'(0));
    chk_state("R1");

    run_op(3'd1, 3'd0, '0, '0);                       // R8 pop of empty stack
    run_op(3'd2, 3'd3, '0, '0);                       // R8 read of empty
    for (int k = 0; k < 8; k++) run_op(3'd0, 3'd0, mkval(k + 1), '0); // R2, wraps 0 to 7
    run_op(3'd0, 3'd0, mkval(99), '0);                // R3 overflow on full stack
    for (int k = 0; k < 8; k++) run_op(3'd2, 3'(k), '0, '0); // R5 every relative slot
    run_op(3'd5, 3'd1, mkval(7), mkval(8));           // R9 reserved code
    run_op(3'd7, 3'd2, mkval(7), mkval(8));           // R9 reserved code
    @(negedge clk); op_vld = 1'b0; op_code = 3'd0;     // R9 idle cycle
    @(posedge clk); #1; chk_state("R9");
    run_op(3'd3, 3'd0, '0, mkval(200));               // R6 arithmetic writeback
    run_op(3'd4, 3'd2, '0, mkval(201));               // R7 register pop
    run_op(3'd4, 3'd0, '0, mkval(202));               // R7 idx 0 result released
    for (int k = 0; k < 6; k++) run_op(3'd1, 3'd0, '0, '0); // R4 drain with wrap 7 to 0
    run_op(3'd3, 3'd0, '0, mkval(203));               // R8 arith on empty

    for (int n = 0; n < 600; n++) begin
      int r;
      logic [2:0] c;
      r = $urandom % 10;
      if (r < 4)       c = 3'd0;
      else if (r < 6)  c = 3'd1;
      else if (r == 6) c = 3'd2;
      else if (r == 7) c = 3'd3;
      else if (r == 8) c = 3'd4;
      else             c = 3'(5 + $urandom % 3);
      run_op(c, 3'($urandom), {$urandom, $urandom, 16'($urandom)},
             {$urandom, $urandom, 16'($urandom)});
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule